// File: doc/BRIEF.md
# Adder-Reuse Low-Power ALU

A 32-bit combinational arithmetic and logic unit built around one shared adder. Every operation is produced by conditioning the two operands before they reach the adder and then choosing among the adder's sum and its bitwise propagate and generate vectors. Each operand path can invert its value, force it to zero or force it to all ones. A 2-bit select then chooses the sum, the propagate vector, the generate vector or the inverted generate vector.

The unit is selected by a 4-bit opcode. An enable input isolates the operand inputs: while it is low, the operands seen by the adder are held at zero, so changes on the operand pins cause no switching inside the unit. The result is only meaningful while the enable is high. There are no flags and no multi-cycle operations.

Top module: `alu_reuse_top`

## Requirements
- R1: With en_i high and opcode 0 (ADD), result_o equals (a_i + b_i) mod 2^32 in the same cycle, with no register on the path.
- R2: With en_i high and opcode 1 (SUB), result_o equals (a_i - b_i) mod 2^32.
- R3: With en_i high, opcode 2 (INC) gives a_i + 1, opcode 3 (DEC) gives a_i - 1 and opcode 4 (NEG) gives 0 - a_i, all mod 2^32.
- R4: With en_i high, opcode 5 (AND) gives a_i & b_i, opcode 6 (OR) gives a_i | b_i and opcode 7 (XOR) gives a_i ^ b_i.
- R5: With en_i high, opcode 8 (XNOR) gives ~(a_i ^ b_i), opcode 9 (NAND) gives ~(a_i & b_i) and opcode 10 (NOR) gives ~(a_i | b_i).
- R6: With en_i high, opcode 11 (NOT) gives ~a_i, opcode 12 (PASS A) gives a_i and opcode 13 (PASS B) gives b_i.
- R7: With en_i high, opcode 14 (ZERO) and the unused opcode 15 both give 0 for any operands.
- R8: While en_i is low, result_o does not change when a_i and b_i change with the opcode held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Operand isolation enable; low holds the internal operands at zero |
| opcode_i | input | 4 | Operation code, encodings as in the requirements |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Operation result |

## Verification
The hardest cases to reach are the carry extremes of the shared adder: a carry rippling across all 32 bits on INC of all ones, a full borrow on DEC of zero, and NEG of the most negative value, which only arise from specific operand values that random stimulus almost never produces. The stimulus therefore mixes seeded random operands across all fifteen opcodes and the unused code with directed all-ones, all-zeros and sign-bit patterns. Isolation is observed at the pins by holding the opcode with the enable low, recording the result, changing both operands and confirming the result has not moved.

// File: rtl/alu_reuse_pkg.sv
`timescale 1ns/1ps
package alu_reuse_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_INC   = 4'd2,
    OP_DEC   = 4'd3,
    OP_NEG   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_XNOR  = 4'd8,
    OP_NAND  = 4'd9,
    OP_NOR   = 4'd10,
    OP_NOT   = 4'd11,
    OP_PASSA = 4'd12,
    OP_PASSB = 4'd13,
    OP_ZERO  = 4'd14,
    OP_RSVD  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_SUM  = 2'd0,
    SEL_PROP = 2'd1,
    SEL_GEN  = 2'd2,
    SEL_NGEN = 2'd3
  } out_sel_e;

  typedef struct packed {
    logic inv;
    logic clr;
    logic set;
  } opnd_ctl_t;

  typedef struct packed {
    opnd_ctl_t a;
    opnd_ctl_t b;
    logic      cin;
    out_sel_e  sel;
  } alu_ctl_t;
endpackage

// File: rtl/alu_reuse_decode.sv
`timescale 1ns/1ps
module alu_reuse_decode
  import alu_reuse_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output alu_ctl_t        ctl_o
);
  localparam opnd_ctl_t KEEP = '{inv: 1'b0, clr: 1'b0, set: 1'b0};
  localparam opnd_ctl_t FLIP = '{inv: 1'b1, clr: 1'b0, set: 1'b0};
  localparam opnd_ctl_t ZERO = '{inv: 1'b0, clr: 1'b1, set: 1'b0};
  localparam opnd_ctl_t ONES = '{inv: 1'b0, clr: 1'b0, set: 1'b1};

  always_comb begin
    ctl_o = '{a: ZERO, b: ZERO, cin: 1'b0, sel: SEL_PROP};
    unique case (alu_op_e'(opcode_i))
      OP_ADD:   ctl_o = '{a: KEEP, b: KEEP, cin: 1'b0, sel: SEL_SUM};
      OP_SUB:   ctl_o = '{a: KEEP, b: FLIP, cin: 1'b1, sel: SEL_SUM};
      OP_INC:   ctl_o = '{a: KEEP, b: ZERO, cin: 1'b1, sel: SEL_SUM};
      OP_DEC:   ctl_o = '{a: KEEP, b: ONES, cin: 1'b0, sel: SEL_SUM};
      OP_NEG:   ctl_o = '{a: FLIP, b: ZERO, cin: 1'b1, sel: SEL_SUM};
      OP_AND:   ctl_o = '{a: KEEP, b: KEEP, cin: 1'b0, sel: SEL_GEN};
      // OR via De Morgan: ~(~a & ~b)
      OP_OR:    ctl_o = '{a: FLIP, b: FLIP, cin: 1'b0, sel: SEL_NGEN};
      OP_XOR:   ctl_o = '{a: KEEP, b: KEEP, cin: 1'b0, sel: SEL_PROP};
      OP_XNOR:  ctl_o = '{a: KEEP, b: FLIP, cin: 1'b0, sel: SEL_PROP};
      OP_NAND:  ctl_o = '{a: KEEP, b: KEEP, cin: 1'b0, sel: SEL_NGEN};
      OP_NOR:   ctl_o = '{a: FLIP, b: FLIP, cin: 1'b0, sel: SEL_GEN};
      OP_NOT:   ctl_o = '{a: FLIP, b: ZERO, cin: 1'b0, sel: SEL_PROP};
      OP_PASSA: ctl_o = '{a: KEEP, b: ZERO, cin: 1'b0, sel: SEL_PROP};
      OP_PASSB: ctl_o = '{a: ZERO, b: KEEP, cin: 1'b0, sel: SEL_PROP};
      default:  ctl_o = '{a: ZERO, b: ZERO, cin: 1'b0, sel: SEL_PROP};
    endcase
  end
endmodule

// File: rtl/alu_reuse_opnd.sv
`timescale 1ns/1ps
module alu_reuse_opnd
  import alu_reuse_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  opnd_ctl_t    ctl_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] forced;

  always_comb begin
    if (ctl_i.set)      forced = '1;
    else if (ctl_i.clr) forced = '0;
    else                forced = x_i;
    y_o = forced ^ {W{ctl_i.inv}};
  end
endmodule

// File: rtl/alu_reuse_adder.sv
`timescale 1ns/1ps
module alu_reuse_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] gen_o
);
  logic [W:0] carry;

  assign prop_o   = a_i ^ b_i;
  assign gen_o    = a_i & b_i;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1] = gen_o[i] | (prop_o[i] & carry[i]);
    assign sum_o[i]   = prop_o[i] ^ carry[i];
  end
endmodule

// File: rtl/alu_reuse_top.sv
`timescale 1ns/1ps
module alu_reuse_top
  import alu_reuse_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            en_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    result_o
);
  alu_ctl_t     ctl;
  logic [W-1:0] a_iso, b_iso;
  logic [W-1:0] a_cond, b_cond;
  logic [W-1:0] sum, prop, gen;

  // operand isolation: idle unit sees constant zero
  assign a_iso = a_i & {W{en_i}};
  assign b_iso = b_i & {W{en_i}};

  alu_reuse_decode u_dec (
    .opcode_i (opcode_i),
    .ctl_o    (ctl)
  );

  alu_reuse_opnd #(.W(W)) u_opnd_a (
    .x_i   (a_iso),
    .ctl_i (ctl.a),
    .y_o   (a_cond)
  );

  alu_reuse_opnd #(.W(W)) u_opnd_b (
    .x_i   (b_iso),
    .ctl_i (ctl.b),
    .y_o   (b_cond)
  );

  alu_reuse_adder #(.W(W)) u_add (
    .a_i    (a_cond),
    .b_i    (b_cond),
    .cin_i  (ctl.cin),
    .sum_o  (sum),
    .prop_o (prop),
    .gen_o  (gen)
  );

  always_comb begin
    unique case (ctl.sel)
      SEL_SUM:  result_o = sum;
      SEL_PROP: result_o = prop;
      SEL_GEN:  result_o = gen;
      default:  result_o = ~gen;
    endcase
  end
endmodule

// File: rtl/alu_reuse_chk.sv
`timescale 1ns/1ps
module alu_reuse_chk #(
  parameter int W = 32
) (
  input logic         en_i,
  input logic [3:0]   opcode_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic [W-1:0] a_iso,
  input logic [W-1:0] b_iso,
  input logic [W-1:0] prop,
  input logic [W-1:0] gen
);
  always_comb begin
    // R8: idle unit presents constant operands to the adder
    if (!en_i) begin
      p_iso_a_r8: assert (a_iso == '0);
      p_iso_b_r8: assert (b_iso == '0);
    end
    // R4: propagate and generate bits never set together
    p_pg_disjoint_r4: assert ((prop & gen) == '0);
    if (en_i && opcode_i == 4'd0) p_add_r1: assert (result_o == W'(a_i + b_i));
    if (en_i && opcode_i == 4'd1) p_sub_r2: assert (result_o == W'(a_i - b_i));
    if (en_i && opcode_i == 4'd7) p_xor_r4: assert (result_o == (a_i ^ b_i));
    if (en_i && opcode_i >= 4'd14) p_zero_r7: assert (result_o == '0);
  end
endmodule

bind alu_reuse_top alu_reuse_chk #(.W(W)) u_chk (
  .en_i     (en_i),
  .opcode_i (opcode_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .a_iso    (a_iso),
  .b_iso    (b_iso),
  .prop     (prop),
  .gen      (gen)
);

// File: tb/alu_reuse_top_tb.sv
`timescale 1ns/1ps
module alu_reuse_top_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         en;
  logic [3:0]   opcode;
  logic [W-1:0] a, b;
  logic [W-1:0] result;
  int           n_checks = 0;
  int           n_fails  = 0;

  always #2.5 clk = ~clk;

  alu_reuse_top #(.W(W)) u_dut (
    .en_i     (en),
    .opcode_i (opcode),
    .a_i      (a),
    .b_i      (b),
    .result_o (result)
  );

  function automatic logic [W-1:0] model(input logic [3:0] op,
                                         input logic [W-1:0] x, input logic [W-1:0] y);
    case (op)
      4'd0:    return x + y;
      4'd1:    return x - y;
      4'd2:    return x + 1;
      4'd3:    return x - 1;
      4'd4:    return 0 - x;
      4'd5:    return x & y;
      4'd6:    return x | y;
      4'd7:    return x ^ y;
      4'd8:    return ~(x ^ y);
      4'd9:    return ~(x & y);
      4'd10:   return ~(x | y);
      4'd11:   return ~x;
      4'd12:   return x;
      4'd13:   return y;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:                   return "R1";
      4'd1:                   return "R2";
      4'd2, 4'd3, 4'd4:       return "R3";
      4'd5, 4'd6, 4'd7:       return "R4";
      4'd8, 4'd9, 4'd10:      return "R5";
      4'd11, 4'd12, 4'd13:    return "R6";
      default:                return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, opcode, a, b, act, exp);
    end
  endtask

  // drive away from the edge, sample 1 ns later (combinational path)
  task automatic apply(input logic [3:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    en = 1'b1; opcode = op; a = x; b = y;
    #1;
    check(tag_of(op), result, model(op, x, y));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(5ns * 200000);
    n_fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd1729));
    en = 1'b0; opcode = '0; a = '0; b = '0;
    repeat (2) @(negedge clk);

    // directed corners
    apply(4'd0, 32'hFFFF_FFFF, 32'h0000_0001);   // R1 wrap
    apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001);   // R1 sign crossing
    apply(4'd1, 32'h0000_0000, 32'h0000_0001);   // R2 full borrow
    apply(4'd1, 32'h8000_0000, 32'h0000_0001);   // R2
    apply(4'd2, 32'hFFFF_FFFF, 32'h1234_5678);   // R3 inc ripple
    apply(4'd3, 32'h0000_0000, 32'h1234_5678);   // R3 dec borrow
    apply(4'd4, 32'h8000_0000, 32'h0);           // R3 neg min
    apply(4'd4, 32'h0000_0000, 32'h0);           // R3 neg zero
    apply(4'd6, 32'hF0F0_0000, 32'h0F0F_0000);   // R4
    apply(4'd10, 32'h0, 32'h0);                  // R5 nor zero
    apply(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R5 nand ones
    apply(4'd11, 32'hFFFF_FFFF, 32'h0);          // R6
    apply(4'd13, 32'hFFFF_FFFF, 32'hA5A5_5A5A);  // R6
    apply(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R7 zero
    apply(4'd15, 32'hDEAD_BEEF, 32'hCAFE_F00D);  // R7 reserved

    // seeded random over every code
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 40; k++) begin
        apply(4'(op), $urandom(), $urandom());
      end
    end

    // R8: idle unit ignores operand changes
    for (int op = 0; op < 16; op++) begin
      @(negedge clk);
      en = 1'b0; opcode = 4'(op); a = $urandom(); b = $urandom();
      #1 held = result;
      @(negedge clk);
      a = ~a; b = $urandom();
      #1 check("R8", result, held);
    end

    summary();
    $finish;
  end
endmodule